// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block supervises a processor from inside a synchronous design. An external comparator supplies a supply-good flag. The block turns that flag into an active-low and an active-high reset and an immediate low-line flag. It runs a watchdog on a three-level input, where a driven high or low level keeps the watchdog armed and an undriven or mid level disables it. It also gates a chip-enable line by the reset state. Only one short hold-over lets an access that is already in progress finish.

All periods are counted in ticks of a clock enable. When `ext_src_i` is low, an internal prescaler produces one tick every `PRESCALE` clocks. When it is high, each rising edge of the external clock `ext_clk_i` produces one tick, after that clock passes through a synchroniser. The same tick paces both the reset-active period and the watchdog timeout.

There are three state machines:
- **Reset sequencer.** States HOLD, DELAY and RUN. HOLD goes to DELAY when the supply is good. DELAY goes to RUN once the count expires. RUN goes to DELAY on a watchdog expiry. Any state goes to HOLD when the supply drops.
- **Watchdog.** States OFF, ARM and FAULT. OFF goes to ARM when the input becomes driven. ARM goes to FAULT on expiry. FAULT goes to ARM on a level change. Both ARM and FAULT go to OFF when the input becomes undriven.
- **Chip-enable gate.** States PASS, KEEP and BLOCK. PASS goes to KEEP when reset rises while chip-enable is low, and to BLOCK when reset rises otherwise. KEEP goes to BLOCK when the hold-over ends or the input goes high. KEEP and BLOCK both go to PASS when reset releases.

Top module: `supv_ctrl`

## Requirements
- R1: `rst_n_o` is low in the same cycle that `pwr_ok_i` is low. After `pwr_ok_i` returns high, `rst_n_o` stays low until `RST_TICKS` ticks have been counted.
- R2: `low_line_n_o` equals `pwr_ok_i` in every cycle, with no delay in either direction.
- R3: With `ext_src_i`=0, a tick occurs every `PRESCALE` clocks. With `ext_src_i`=1, a tick occurs once per rising edge of `ext_clk_i`. That tick paces both the reset period and the watchdog.
- R4: The watchdog expires on the `WD_SHORT`-th tick without a level change when `long_sel_i`=0, and on the `WD_LONG`-th such tick when `long_sel_i`=1.
- R5: `wd_lvl_i` is encoded as 2'b00 for low, 2'b01 for high, and 2'b1x for undriven. Any change of `wd_lvl_i` restarts the watchdog count from zero.
- R6: On expiry, `rst_n_o` and `wd_fault_n_o` both fall on the same clock edge. The reset pulse lasts `RST_TICKS` ticks, the same as a supply reset.
- R7: `wd_fault_n_o` stays low after expiry, including after the reset pulse ends, until `wd_lvl_i` changes. While `wd_lvl_i` is undriven, the watchdog is disabled and `wd_fault_n_o` is high.
- R8: While reset is inactive, `ce_n_o` equals `ce_n_i`. During reset `ce_n_o` is high, except during the hold-over of R9. `ce_n_o` is never low while `ce_n_i` is high.
- R9: If `ce_n_i` is low in the cycle that reset asserts, `ce_n_o` stays low in that cycle and for `CE_HOLD_CYC` further clocks. It goes high earlier if `ce_n_i` goes high, and stays high even if `ce_n_i` returns low.
- R10: `rst_o` is always the inverse of `rst_n_o`.
- R11: The watchdog count is held at zero while reset is active. It starts counting with the first tick after reset ends.
- R12: While `rst_n` is low, the block is in the following state: `rst_n_o` is low, `wd_fault_n_o` is high and `ce_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| pwr_ok_i | input | 1 | Supply-good flag from the comparator |
| wd_lvl_i | input | 2 | Decoded watchdog level: 00 low, 01 high, 1x undriven |
| ce_n_i | input | 1 | Chip-enable input, active low |
| ext_src_i | input | 1 | 1 selects the external clock as the tick source |
| ext_clk_i | input | 1 | External timing clock |
| long_sel_i | input | 1 | 1 selects the long watchdog timeout |
| rst_n_o | output | 1 | Reset, active low |
| rst_o | output | 1 | Reset, active high |
| low_line_n_o | output | 1 | Low-line flag, low while the supply is bad |
| wd_fault_n_o | output | 1 | Watchdog fault, active low |
| ce_n_o | output | 1 | Gated chip-enable, active low |

## Verification
The following outputs respond combinationally, so each is checked one time unit after the falling edge on which its input changed:
- `low_line_n_o`.
- The assertion of reset.
- `ce_n_o` while reset is inactive.

A level change on `wd_lvl_i` clears the fault, and changes the watchdog state, on the next clock edge. The checks therefore wait one full clock after applying each table row.

An external tick is consumed on the third clock edge after `ext_clk_i` rises. The bench produces each tick with a four-clock pulse, so every tick is settled before the next check. Reset release and watchdog expiry are then checked after exact tick counts.

The hold-over is sampled on each falling edge for `CE_HOLD_CYC`+1 cycles after reset asserts. The internal prescaler's phase is free-running, so internal mode is checked against the window of clock counts that the phase allows.

// File: rtl/supv_pkg.sv
package supv_pkg;

    typedef logic [1:0] wd_lvl_t;

    typedef enum logic [1:0] {
        RS_HOLD  = 2'd0,
        RS_DELAY = 2'd1,
        RS_RUN   = 2'd2
    } rs_state_e;

    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_ARM   = 2'd1,
        WD_FAULT = 2'd2
    } wd_state_e;

    typedef enum logic [1:0] {
        CE_PASS  = 2'd0,
        CE_KEEP  = 2'd1,
        CE_BLOCK = 2'd2
    } ce_state_e;

    // Upper bit set means the line is undriven or at mid level (R5, R7)
    function automatic logic lvl_driven(wd_lvl_t lvl);
        return !lvl[1];
    endfunction

endpackage

// File: rtl/supv_tick.sv
module supv_tick #(
    parameter int PRESCALE    = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_src_i,
    input  logic ext_clk_i,
    output logic tick_o
);

    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic tick_int;
    logic tick_ext;
    logic [SYNC_STAGES-1:0] sync_q;
    logic ext_last_q;

    // Internal tick source (R3)
    generate
        if (PRESCALE <= 1) begin : g_every
            assign tick_int = 1'b1;
        end else begin : g_div
            logic [PW-1:0] div_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    div_q <= '0;
                end else if (div_q == PW'(PRESCALE - 1)) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end
            assign tick_int = (div_q == PW'(PRESCALE - 1));
        end
    endgenerate

    // External tick source: synchronise, then detect the rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q     <= '0;
            ext_last_q <= 1'b0;
        end else begin
            sync_q     <= {sync_q[SYNC_STAGES-2:0], ext_clk_i};
            ext_last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign tick_ext = sync_q[SYNC_STAGES-1] & ~ext_last_q;
    assign tick_o   = ext_src_i ? tick_ext : tick_int;

endmodule

// File: rtl/supv_rst_seq.sv
module supv_rst_seq
    import supv_pkg::*;
#(
    parameter int RST_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok_i,
    input  logic tick_i,
    input  logic wd_expire_i,
    output logic rst_act_o
);

    localparam int CW = $clog2(RST_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(RST_TICKS - 1);

    rs_state_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RS_HOLD;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            RS_HOLD: begin
                st_d  = RS_DELAY;
                cnt_d = '0;
            end
            RS_DELAY: begin
                if (tick_i) begin
                    if (cnt_q == LAST) begin
                        st_d  = RS_RUN;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            RS_RUN: begin
                if (wd_expire_i) begin
                    st_d  = RS_DELAY;   // watchdog pulse, same length (R6)
                    cnt_d = '0;
                end
            end
            default: begin
                st_d  = RS_HOLD;
                cnt_d = '0;
            end
        endcase
        if (!pwr_ok_i) begin
            st_d  = RS_HOLD;
            cnt_d = '0;
        end
    end

    // Output: reset asserts combinationally on supply loss (R1)
    always_comb begin
        rst_act_o = !((st_q == RS_RUN) && pwr_ok_i);
    end

endmodule

// File: rtl/supv_wdog.sv
module supv_wdog
    import supv_pkg::*;
#(
    parameter int WD_SHORT = 100,
    parameter int WD_LONG  = 1600
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick_i,
    input  logic    rst_act_i,
    input  logic    long_sel_i,
    input  wd_lvl_t wd_lvl_i,
    output logic    expire_o,
    output logic    fault_o
);

    localparam int WD_MAX = (WD_LONG > WD_SHORT) ? WD_LONG : WD_SHORT;
    localparam int CW     = $clog2(WD_MAX + 1);

    wd_state_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    wd_lvl_t lvl_q;
    logic driven;
    logic lvl_edge;
    logic expire_d;
    logic [CW-1:0] limit;

    assign driven   = lvl_driven(wd_lvl_i);
    assign lvl_edge = (wd_lvl_i != lvl_q);
    assign limit    = long_sel_i ? CW'(WD_LONG - 1) : CW'(WD_SHORT - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= WD_OFF;
            cnt_q <= '0;
            lvl_q <= 2'b10;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            lvl_q <= wd_lvl_i;
        end
    end

    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        expire_d = 1'b0;
        unique case (st_q)
            WD_OFF: begin
                cnt_d = '0;
                if (driven) begin
                    st_d = WD_ARM;
                end
            end
            WD_ARM: begin
                if (!driven) begin
                    st_d  = WD_OFF;
                    cnt_d = '0;
                end else if (lvl_edge || rst_act_i) begin
                    cnt_d = '0;                       // R5, R11
                end else if (tick_i) begin
                    if (cnt_q >= limit) begin
                        expire_d = 1'b1;              // R4
                        st_d     = WD_FAULT;
                        cnt_d    = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            WD_FAULT: begin
                cnt_d = '0;
                if (!driven) begin
                    st_d = WD_OFF;                    // R7
                end else if (lvl_edge) begin
                    st_d = WD_ARM;                    // R7
                end
            end
            default: begin
                st_d  = WD_OFF;
                cnt_d = '0;
            end
        endcase
    end

    always_comb begin
        fault_o  = (st_q == WD_FAULT);
        expire_o = expire_d;
    end

endmodule

// File: rtl/supv_ce_gate.sv
module supv_ce_gate
    import supv_pkg::*;
#(
    parameter int CE_HOLD_CYC = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_act_i,
    input  logic ce_n_i,
    output logic ce_n_o
);

    localparam int CW = $clog2(CE_HOLD_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(CE_HOLD_CYC - 1);

    ce_state_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= CE_BLOCK;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            CE_PASS: begin
                cnt_d = '0;
                if (rst_act_i) begin
                    st_d = ce_n_i ? CE_BLOCK : CE_KEEP;
                end
            end
            CE_KEEP: begin
                if (!rst_act_i) begin
                    st_d  = CE_PASS;
                    cnt_d = '0;
                end else if (ce_n_i || (cnt_q == LAST)) begin
                    st_d  = CE_BLOCK;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            CE_BLOCK: begin
                cnt_d = '0;
                if (!rst_act_i) begin
                    st_d = CE_PASS;
                end
            end
            default: begin
                st_d  = CE_BLOCK;
                cnt_d = '0;
            end
        endcase
    end

    // R8, R9
    always_comb begin
        if (!rst_act_i) begin
            ce_n_o = ce_n_i;
        end else begin
            unique case (st_q)
                CE_PASS:  ce_n_o = ce_n_i;
                CE_KEEP:  ce_n_o = ce_n_i;
                default:  ce_n_o = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/supv_ctrl.sv
module supv_ctrl
    import supv_pkg::*;
#(
    parameter int PRESCALE    = 1000,
    parameter int SYNC_STAGES = 2,
    parameter int RST_TICKS   = 200,
    parameter int WD_SHORT    = 100,
    parameter int WD_LONG     = 1600,
    parameter int CE_HOLD_CYC = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_ok_i,
    input  logic [1:0] wd_lvl_i,
    input  logic       ce_n_i,
    input  logic       ext_src_i,
    input  logic       ext_clk_i,
    input  logic       long_sel_i,
    output logic       rst_n_o,
    output logic       rst_o,
    output logic       low_line_n_o,
    output logic       wd_fault_n_o,
    output logic       ce_n_o
);

    logic tick;
    logic rst_act;
    logic wd_expire;
    logic wd_fault;

    supv_tick #(
        .PRESCALE    (PRESCALE),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_src_i (ext_src_i),
        .ext_clk_i (ext_clk_i),
        .tick_o    (tick)
    );

    supv_rst_seq #(
        .RST_TICKS (RST_TICKS)
    ) u_rst_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_ok_i    (pwr_ok_i),
        .tick_i      (tick),
        .wd_expire_i (wd_expire),
        .rst_act_o   (rst_act)
    );

    supv_wdog #(
        .WD_SHORT (WD_SHORT),
        .WD_LONG  (WD_LONG)
    ) u_wdog (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .rst_act_i  (rst_act),
        .long_sel_i (long_sel_i),
        .wd_lvl_i   (wd_lvl_i),
        .expire_o   (wd_expire),
        .fault_o    (wd_fault)
    );

    supv_ce_gate #(
        .CE_HOLD_CYC (CE_HOLD_CYC)
    ) u_ce_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_act_i (rst_act),
        .ce_n_i    (ce_n_i),
        .ce_n_o    (ce_n_o)
    );

    assign rst_n_o      = ~rst_act;
    assign rst_o        = rst_act;      // R10
    assign low_line_n_o = pwr_ok_i;     // R2
    assign wd_fault_n_o = ~wd_fault;

endmodule

// File: rtl/supv_ctrl_chk.sv
module supv_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_ok_i,
    input logic wd_undriven,
    input logic ce_n_i,
    input logic rst_n_o,
    input logic low_line_n_o,
    input logic wd_fault_n_o,
    input logic ce_n_o
);

    p_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok_i |-> !rst_n_o);

    p_rise_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_ok_i) |-> !rst_n_o);

    p_lowline_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !low_line_n_o |-> !rst_n_o);

    p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_fault_n_o) |-> !rst_n_o);

    p_mid_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wd_undriven) |-> wd_fault_n_o);

    p_ce_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n_o |-> !ce_n_i);

    p_ce_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n_o |-> (ce_n_o == ce_n_i));

endmodule

bind supv_ctrl supv_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_ok_i     (pwr_ok_i),
    .wd_undriven  (wd_lvl_i[1]),
    .ce_n_i       (ce_n_i),
    .rst_n_o      (rst_n_o),
    .low_line_n_o (low_line_n_o),
    .wd_fault_n_o (wd_fault_n_o),
    .ce_n_o       (ce_n_o)
);

// File: tb/test_supv_ctrl.sv
module test_supv_ctrl;

    localparam int CLK_PERIOD  = 10;
    localparam int PRESCALE    = 4;
    localparam int RST_TICKS   = 4;
    localparam int WD_SHORT    = 3;
    localparam int WD_LONG     = 6;
    localparam int CE_HOLD_CYC = 3;
    localparam int NROW        = 23;

    // Row: {pwr, ce_n, wd[1:0], long, pulses[3:0], exp_rst_n, exp_fault_n, exp_ce_n, exp_ll_n, req[3:0]}
    localparam logic [16:0] TBL [NROW] = '{
        {1'b0,1'b1,2'd2,1'b0,4'd0, 1'b0,1'b1,1'b1,1'b0, 4'd1},  // R1 supply low
        {1'b1,1'b1,2'd2,1'b0,4'd3, 1'b0,1'b1,1'b1,1'b1, 4'd1},  // R1 one tick short
        {1'b1,1'b1,2'd2,1'b0,4'd1, 1'b1,1'b1,1'b1,1'b1, 4'd1},  // R1 released
        {1'b1,1'b1,2'd2,1'b0,4'd8, 1'b1,1'b1,1'b1,1'b1, 4'd7},  // R7 undriven disables
        {1'b1,1'b1,2'd0,1'b0,4'd2, 1'b1,1'b1,1'b1,1'b1, 4'd4},  // R4 armed low
        {1'b1,1'b1,2'd1,1'b0,4'd2, 1'b1,1'b1,1'b1,1'b1, 4'd5},  // R5 edge restarts
        {1'b1,1'b1,2'd1,1'b0,4'd1, 1'b0,1'b0,1'b1,1'b1, 4'd6},  // R6 expiry
        {1'b1,1'b1,2'd1,1'b0,4'd3, 1'b0,1'b0,1'b1,1'b1, 4'd6},  // R6 pulse held
        {1'b1,1'b1,2'd1,1'b0,4'd1, 1'b1,1'b0,1'b1,1'b1, 4'd6},  // R6 pulse ends
        {1'b1,1'b1,2'd1,1'b0,4'd5, 1'b1,1'b0,1'b1,1'b1, 4'd7},  // R7 latched
        {1'b1,1'b1,2'd0,1'b0,4'd0, 1'b1,1'b1,1'b1,1'b1, 4'd7},  // R7 edge clears
        {1'b1,1'b0,2'd0,1'b0,4'd0, 1'b1,1'b1,1'b0,1'b1, 4'd8},  // R8 pass low
        {1'b1,1'b1,2'd2,1'b0,4'd0, 1'b1,1'b1,1'b1,1'b1, 4'd8},  // R8 pass high
        {1'b1,1'b1,2'd1,1'b1,4'd5, 1'b1,1'b1,1'b1,1'b1, 4'd4},  // R4 long not yet
        {1'b1,1'b1,2'd1,1'b1,4'd1, 1'b0,1'b0,1'b1,1'b1, 4'd4},  // R4 long expiry
        {1'b1,1'b1,2'd2,1'b1,4'd4, 1'b1,1'b1,1'b1,1'b1, 4'd7},  // R7 undriven clears
        {1'b0,1'b1,2'd2,1'b0,4'd0, 1'b0,1'b1,1'b1,1'b0, 4'd2},  // R2 low line
        {1'b1,1'b1,2'd2,1'b0,4'd4, 1'b1,1'b1,1'b1,1'b1, 4'd2},  // R2 back high
        {1'b0,1'b1,2'd1,1'b0,4'd5, 1'b0,1'b1,1'b1,1'b0, 4'd11}, // R11 held in reset
        {1'b1,1'b1,2'd1,1'b0,4'd4, 1'b1,1'b1,1'b1,1'b1, 4'd11}, // R11 reset ends
        {1'b1,1'b1,2'd1,1'b0,4'd2, 1'b1,1'b1,1'b1,1'b1, 4'd11}, // R11 counting fresh
        {1'b1,1'b1,2'd1,1'b0,4'd1, 1'b0,1'b0,1'b1,1'b1, 4'd11}, // R11 expiry
        {1'b1,1'b1,2'd2,1'b0,4'd4, 1'b1,1'b1,1'b1,1'b1, 4'd3}   // R3 external ticks
    };

    logic       clk;
    logic       rst_n;
    logic       pwr_ok_i;
    logic [1:0] wd_lvl_i;
    logic       ce_n_i;
    logic       ext_src_i;
    logic       ext_clk_i;
    logic       long_sel_i;
    logic       rst_n_o;
    logic       rst_o;
    logic       low_line_n_o;
    logic       wd_fault_n_o;
    logic       ce_n_o;

    int n_tests = 0;
    int n_fail  = 0;

    supv_ctrl #(
        .PRESCALE    (PRESCALE),
        .SYNC_STAGES (2),
        .RST_TICKS   (RST_TICKS),
        .WD_SHORT    (WD_SHORT),
        .WD_LONG     (WD_LONG),
        .CE_HOLD_CYC (CE_HOLD_CYC)
    ) i_supv_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_ok_i     (pwr_ok_i),
        .wd_lvl_i     (wd_lvl_i),
        .ce_n_i       (ce_n_i),
        .ext_src_i    (ext_src_i),
        .ext_clk_i    (ext_clk_i),
        .long_sel_i   (long_sel_i),
        .rst_n_o      (rst_n_o),
        .rst_o        (rst_o),
        .low_line_n_o (low_line_n_o),
        .wd_fault_n_o (wd_fault_n_o),
        .ce_n_o       (ce_n_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // One external tick; starts and ends on a falling edge
    task automatic ext_pulse();
        ext_clk_i = 1'b1;
        repeat (2) @(negedge clk);
        ext_clk_i = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic ext_ticks(input int n);
        for (int p = 0; p < n; p++) ext_pulse();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL R12 watchdog: actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        pwr_ok_i   = 1'b1;
        wd_lvl_i   = 2'b10;
        ce_n_i     = 1'b0;
        ext_src_i  = 1'b1;
        ext_clk_i  = 1'b0;
        long_sel_i = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        // R12 state during system reset
        check("R12", "rst_n_o", rst_n_o, 1'b0);
        check("R12", "wd_fault_n_o", wd_fault_n_o, 1'b1);
        check("R12", "ce_n_o", ce_n_o, 1'b1);
        check("R10", "rst_o", rst_o, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table walk
        for (int i = 0; i < NROW; i++) begin
            logic [16:0] row;
            string tag;
            row = TBL[i];
            tag = $sformatf("R%0d row%0d", row[3:0], i);
            @(negedge clk);
            pwr_ok_i   = row[16];
            ce_n_i     = row[15];
            wd_lvl_i   = row[14:13];
            long_sel_i = row[12];
            @(negedge clk);
            ext_ticks(int'(row[11:8]));
            #1;
            check(tag, "rst_n_o", rst_n_o, row[7]);
            check($sformatf("R10 row%0d", i), "rst_o", rst_o, ~row[7]);
            check(tag, "wd_fault_n_o", wd_fault_n_o, row[6]);
            check(tag, "ce_n_o", ce_n_o, row[5]);
            check(tag, "low_line_n_o", low_line_n_o, row[4]);
        end

        // R9 hold-over for its full length
        @(negedge clk);
        ce_n_i = 1'b0;
        @(negedge clk);
        pwr_ok_i = 1'b0;
        #1;
        check("R9", "ce_n_o k0", ce_n_o, 1'b0);
        check("R1", "rst_n_o on drop", rst_n_o, 1'b0);
        for (int k = 1; k <= CE_HOLD_CYC + 1; k++) begin
            @(negedge clk);
            #1;
            check("R9", $sformatf("ce_n_o k%0d", k), ce_n_o, (k <= CE_HOLD_CYC) ? 1'b0 : 1'b1);
        end
        @(negedge clk);
        pwr_ok_i = 1'b1;
        ce_n_i   = 1'b1;
        @(negedge clk);
        ext_ticks(RST_TICKS);
        #1;
        check("R1", "rst_n_o restored", rst_n_o, 1'b1);

        // R9 hold-over cut short by chip-enable going high
        @(negedge clk);
        ce_n_i = 1'b0;
        @(negedge clk);
        pwr_ok_i = 1'b0;
        @(negedge clk);
        #1;
        check("R9", "ce_n_o early k1", ce_n_o, 1'b0);
        @(negedge clk);
        ce_n_i = 1'b1;
        #1;
        check("R9", "ce_n_o follows high", ce_n_o, 1'b1);
        @(negedge clk);
        ce_n_i = 1'b0;
        #1;
        check("R9", "ce_n_o blocked after release", ce_n_o, 1'b1);
        @(negedge clk);
        pwr_ok_i = 1'b1;
        ce_n_i   = 1'b1;
        @(negedge clk);
        ext_ticks(RST_TICKS);
        #1;
        check("R8", "rst_n_o restored", rst_n_o, 1'b1);

        // R3 internal prescaler paces the reset period
        @(negedge clk);
        ext_src_i = 1'b0;
        pwr_ok_i  = 1'b0;
        @(negedge clk);
        pwr_ok_i = 1'b1;
        begin
            int c;
            c = 0;
            #1;
            while (!rst_n_o && c < 200) begin
                @(negedge clk);
                #1;
                c++;
            end
            n_tests++;
            if (c < 2 + (RST_TICKS - 1) * PRESCALE || c > 1 + RST_TICKS * PRESCALE) begin
                n_fail++;
                $display("FAIL R3 internal reset length: actual=%0d expected=%0d..%0d",
                         c, 2 + (RST_TICKS - 1) * PRESCALE, 1 + RST_TICKS * PRESCALE);
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule